// File: doc/BRIEF.md
# Double-Buffered Input Gamma Lookup Table

This block maps each colour component of an incoming pixel through a per-channel lookup table before the rest of the colour pipeline sees it. It holds two complete tables, bank A and bank B. Each bank has 256 entries for each of red, green and blue, and each entry is an unsigned u0.12 fraction. The pixel path reads one bank while the host reloads the other. The host then changes the mode, and the switch to the reloaded bank happens at the next frame start, so no frame mixes two tables.

The host uses a four-address register port. It picks the bank to write, a per-channel write mask and the start index. It also sets a memory power-enable and the requested read mode. Loading goes through a single data address that steps through red, green and blue for one index before it moves on to the next index. A read-only status code reports which bank is active, combined with the degamma ROM selection that arrives on a separate input. When the mode is bypass, each component is widened to 12 bits by bit replication.

Top module: `gamma_lut_top`

## Requirements
- R1: Each colour component input is IN_W bits wide (10 by default). Only its top 8 bits index the table, so the low bits have no effect. Each output is the 12-bit u0.12 entry stored at that index for that channel.
- R2: Register map. Address 0 is configuration: bit 0 is the write bank, bits 3:1 are the write mask, bit 4 is power-enable and bits 9:8 are the requested mode. It resets to mask 7 and every other field 0, which reads back as 0x00E. Address 1 holds the index in bits 7:0 and the channel step in bits 9:8 (0 red, 1 green, 2 blue), and resets to 0. Address 2 is the colour data port. Address 3 reads the status code in bits 2:0.
- R3: Writing address 1 sets the index and restarts the step at red. Each accepted write to address 2 goes to the current channel of the current index and then moves the step on. The index increments after the blue step.
- R4: Write mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A channel whose bit is clear keeps its stored value, but its write still moves the step on.
- R5: After the blue write at index 255, the index wraps to 0 with the step at red.
- R6: While power-enable is 0, writes to address 2 are ignored. No entry changes, and the index and step stay where they were.
- R7: Write bank 0 loads bank A and 1 loads bank B. Loading one bank leaves the other bank's outputs unchanged.
- R8: Mode 2 reads bank A and mode 3 reads bank B. Modes 0 and 1 are bypass, where an 8-bit component x is output as x*16 + x/16.
- R9: A new requested mode takes effect only on a cycle where frame_start is high. Until then the pixel path and the status keep the previous mode. The mode in force after reset is bypass.
- R10: The status is 0 in bypass. With bank A active it is 1, 3 or 4, and with bank B active it is 2, 5 or 6, for dgam_rom equal to 0 (none), 1 (ROM A) or 2 (ROM B). A dgam_rom value of 3 reads as none.
- R11: The outputs and out_valid are registered. out_valid equals pix_valid one clock later, and the colour outputs hold their value while no pixel is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 12 | Register write data |
| host_rdata | output | 12 | Register read data (combinational on host_addr) |
| frame_start | input | 1 | Frame boundary strobe; applies the requested mode |
| dgam_rom | input | 2 | Degamma ROM selection reported in the status |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | IN_W | Red component |
| pix_g | input | IN_W | Green component |
| pix_b | input | IN_W | Blue component |
| out_valid | output | 1 | Output valid, one clock after pix_valid |
| out_r | output | 12 | Red result, u0.12 |
| out_g | output | 12 | Green result, u0.12 |
| out_b | output | 12 | Blue result, u0.12 |
| status | output | 3 | Active-bank status code |

## Verification
The assertions assume that reset is applied before any use. They also assume that host_addr and host_we are stable across each clock edge, and that frame_start is a single-cycle strobe driven by the frame logic. The stimulus changes every input only on the falling edge and raises frame_start for exactly one cycle. The pixel path reads a bank only after that bank has been fully loaded, so the table contents are always defined when the sweeps compare them with arithmetic expectations.

// File: rtl/gamma_lut_pkg.sv
`timescale 1ns/1ps
package gamma_lut_pkg;

  typedef enum logic [1:0] {
    PH_R = 2'd0,
    PH_G = 2'd1,
    PH_B = 2'd2
  } ch_phase_e;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_INDEX  = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam int NUM_CH = 3;

  // Mode bit 1 set means a table is used; bit 0 picks the bank (0 = A, 1 = B).
  function automatic logic mode_uses_table(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic mode_bank(input logic [1:0] mode);
    return mode[0];
  endfunction

  // Combined status: bank in use together with the degamma ROM selection.
  function automatic logic [2:0] status_code(input logic [1:0] mode,
                                             input logic [1:0] rom);
    if (!mode_uses_table(mode)) return 3'd0;
    case (rom)
      2'd1:    return mode_bank(mode) ? 3'd5 : 3'd3;
      2'd2:    return mode_bank(mode) ? 3'd6 : 3'd4;
      default: return mode_bank(mode) ? 3'd2 : 3'd1;
    endcase
  endfunction

  function automatic logic [NUM_CH-1:0] phase_onehot(input ch_phase_e ph);
    return 3'b001 << ph;
  endfunction

endpackage

// File: rtl/gamma_lut_bank.sv
`timescale 1ns/1ps
module gamma_lut_bank
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic [NUM_CH-1:0]              ch_we,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [NUM_CH-1:0][IDX_W-1:0]   rd_idx,
  output logic [NUM_CH-1:0][DATA_W-1:0]  rd_data
);
  localparam int ENTRIES = 1 << IDX_W;

  // One storage array per channel so that all three read in parallel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (ch_we[c]) mem[wr_idx] <= wr_data;
    end

    assign rd_data[c] = mem[rd_idx[c]];
  end

endmodule

// File: rtl/gamma_lut_host.sv
`timescale 1ns/1ps
module gamma_lut_host
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [1:0]           host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  input  logic                 frame_start,
  input  logic [1:0]           dgam_rom,
  output logic [1:0]           active_mode,
  output logic [2:0]           status,
  output logic [NUM_CH-1:0]    bank_we_a,
  output logic [NUM_CH-1:0]    bank_we_b,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [DATA_W-1:0]    wr_data
);
  logic              wbank;
  logic [NUM_CH-1:0] wmask;
  logic              pwr_en;
  logic [1:0]        mode_req;
  logic [IDX_W-1:0]  idx;
  ch_phase_e         phase;

  // Named events for the assertions.
  logic cfg_write, index_write, data_fire, data_drop, seq_wrap;
  logic [NUM_CH-1:0] ch_we;

  assign cfg_write   = host_we && (host_addr == ADDR_CFG);
  assign index_write = host_we && (host_addr == ADDR_INDEX);
  assign data_fire   = host_we && (host_addr == ADDR_DATA) && pwr_en;
  assign data_drop   = host_we && (host_addr == ADDR_DATA) && !pwr_en;
  assign seq_wrap    = data_fire && (phase == PH_B) && (idx == {IDX_W{1'b1}});

  function automatic ch_phase_e next_phase(input ch_phase_e ph);
    return (ph == PH_B) ? PH_R : ch_phase_e'(ph + 2'd1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank    <= 1'b0;
      wmask    <= '1;
      pwr_en   <= 1'b0;
      mode_req <= 2'd0;
    end else if (cfg_write) begin
      wbank    <= host_wdata[0];
      wmask    <= host_wdata[3:1];
      pwr_en   <= host_wdata[4];
      mode_req <= host_wdata[9:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_R;
    end else if (index_write) begin
      idx   <= host_wdata[IDX_W-1:0];
      phase <= PH_R;
    end else if (data_fire) begin
      phase <= next_phase(phase);
      if (phase == PH_B) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           active_mode <= 2'd0;
    else if (frame_start) active_mode <= mode_req;
  end

  assign ch_we     = data_fire ? (wmask & phase_onehot(phase)) : '0;
  assign bank_we_a = wbank ? '0 : ch_we;
  assign bank_we_b = wbank ? ch_we : '0;
  assign wr_idx    = idx;
  assign wr_data   = host_wdata;
  assign status    = status_code(active_mode, dgam_rom);

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_CFG: begin
        host_rdata[0]   = wbank;
        host_rdata[3:1] = wmask;
        host_rdata[4]   = pwr_en;
        host_rdata[9:8] = mode_req;
      end
      ADDR_INDEX: begin
        host_rdata[IDX_W-1:0] = idx;
        host_rdata[9:8]       = phase;
      end
      ADDR_STATUS: host_rdata[2:0] = status;
      default:     host_rdata = '0;
    endcase
  end

  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  a_r6_drop_holds_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drop && !index_write) |=> ($stable(idx) && $stable(phase)));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wrap |=> (idx == '0 && phase == PH_R));

  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_mode));

  a_r7_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !((|bank_we_a) && (|bank_we_b)));

  a_r4_masked_ch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_we_a | bank_we_b) & ~wmask) == '0);

endmodule

// File: rtl/gamma_lut_pix.sv
`timescale 1ns/1ps
module gamma_lut_pix
  import gamma_lut_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pix_valid,
  input  logic [NUM_CH-1:0][IN_W-1:0]    pix_in,
  input  logic [1:0]                     active_mode,
  output logic [NUM_CH-1:0][IDX_W-1:0]   rd_idx,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rdata_a,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rdata_b,
  output logic                           out_valid,
  output logic [NUM_CH-1:0][DATA_W-1:0]  out_px
);
  localparam int EXT_W = DATA_W - IDX_W;

  // Bit-replicating widening used in bypass.
  function automatic logic [DATA_W-1:0] widen(input logic [IDX_W-1:0] x);
    return {x, x[IDX_W-1 -: EXT_W]};
  endfunction

  logic [NUM_CH-1:0][DATA_W-1:0] next_px;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_idx[c] = pix_in[c][IN_W-1 -: IDX_W];

    if (IN_W > IDX_W) begin : g_trunc
      logic unused_lsbs;
      assign unused_lsbs = ^pix_in[c][IN_W-IDX_W-1:0];
    end

    always_comb begin
      if (!mode_uses_table(active_mode)) next_px[c] = widen(rd_idx[c]);
      else if (mode_bank(active_mode))   next_px[c] = rdata_b[c];
      else                               next_px[c] = rdata_a[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_px    <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_px <= next_px;
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_px));

endmodule

// File: rtl/gamma_lut_top.sv
`timescale 1ns/1ps
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              frame_start,
  input  logic [1:0]        dgam_rom,
  input  logic              pix_valid,
  input  logic [IN_W-1:0]   pix_r,
  input  logic [IN_W-1:0]   pix_g,
  input  logic [IN_W-1:0]   pix_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_r,
  output logic [DATA_W-1:0] out_g,
  output logic [DATA_W-1:0] out_b,
  output logic [2:0]        status
);
  logic [1:0]                    active_mode;
  logic [NUM_CH-1:0]             bank_we_a, bank_we_b;
  logic [IDX_W-1:0]              wr_idx;
  logic [DATA_W-1:0]             wr_data;
  logic [NUM_CH-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_CH-1:0][DATA_W-1:0] rdata_a, rdata_b, out_px;
  logic [NUM_CH-1:0][IN_W-1:0]   pix_in;

  assign pix_in = {pix_b, pix_g, pix_r};
  assign out_r  = out_px[0];
  assign out_g  = out_px[1];
  assign out_b  = out_px[2];

  gamma_lut_host #(.IDX_W(IDX_W), .DATA_W(DATA_W)) host_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_start(frame_start), .dgam_rom(dgam_rom),
    .active_mode(active_mode), .status(status),
    .bank_we_a(bank_we_a), .bank_we_b(bank_we_b),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  gamma_lut_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) bank_a_i (
    .clk(clk), .ch_we(bank_we_a), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rdata_a)
  );

  gamma_lut_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) bank_b_i (
    .clk(clk), .ch_we(bank_we_b), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rdata_b)
  );

  gamma_lut_pix #(.IN_W(IN_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) pix_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
    .active_mode(active_mode), .rd_idx(rd_idx),
    .rdata_a(rdata_a), .rdata_b(rdata_b),
    .out_valid(out_valid), .out_px(out_px)
  );

  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd6);

  a_r10_status_zero_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode[1] == 1'b0) |-> (status == 3'd0));

endmodule

// File: tb/gamma_lut_top_tb.sv
`timescale 1ns/1ps
module gamma_lut_top_tb_top;
  localparam int IN_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [11:0] host_wdata = '0;
  logic [11:0] host_rdata;
  logic        frame_start = 1'b0;
  logic [1:0]  dgam_rom = 2'd0;
  logic        pix_valid = 1'b0;
  logic [IN_W-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;
  logic [2:0]  status;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gamma_lut_top #(.IN_W(IN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_start(frame_start), .dgam_rom(dgam_rom),
    .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .status(status)
  );

  function automatic int fa(int i, int c);
    return (i * 37 + c * 1365 + 5) % 4096;
  endfunction
  function automatic int fb(int i, int c);
    return (i * 91 + c * 700 + 2000) % 4096;
  endfunction
  function automatic int byp(int x);
    return x * 16 + x / 16;
  endfunction
  function automatic int cfgw(int bank, int mask, int pwr, int mode);
    return bank + mask * 2 + pwr * 16 + mode * 256;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    host_we = 1'b1; host_addr = addr[1:0]; host_wdata = data[11:0];
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    host_addr = addr[1:0];
    #1 data = host_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // Drive one pixel; low input bits vary to exercise truncation.
  task automatic px(input int r, input int g, input int b, input int lsb,
                    output int o_r, output int o_g, output int o_b);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_r = IN_W'(r * 4 + lsb); pix_g = IN_W'(g * 4 + lsb); pix_b = IN_W'(b * 4 + lsb);
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R11 valid one cycle later", out_valid, 1);
    o_r = out_r; o_g = out_g; o_b = out_b;
  endtask

  task automatic load(input int which);
    wr(1, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) wr(2, which ? fb(i, c) : fa(i, c));
  endtask

  task automatic sweep(input int which, input string req);
    int o_r, o_g, o_b;
    for (int i = 0; i < 256; i++) begin
      int g, b;
      g = (i + 85) % 256; b = (i + 170) % 256;
      px(i, g, b, i % 4, o_r, o_g, o_b);
      if (which == 0) begin
        chk(req, o_r, fa(i, 0)); chk(req, o_g, fa(g, 1)); chk(req, o_b, fa(b, 2));
      end else if (which == 1) begin
        chk(req, o_r, fb(i, 0)); chk(req, o_g, fb(g, 1)); chk(req, o_b, fb(b, 2));
      end else begin
        chk(req, o_r, byp(i)); chk(req, o_g, byp(g)); chk(req, o_b, byp(b));
      end
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, o_r, o_g, o_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset out_r", out_r, 0);
    chk("R10 reset status", status, 0);
    rd(0, v); chk("R2 cfg reset", v, 'h00E);
    rd(1, v); chk("R2 index reset", v, 0);

    // Bypass after reset, truncated inputs
    sweep(2, "R8 R1 bypass");
    @(negedge clk);
    chk("R11 idle drops valid", out_valid, 0);

    // Load bank A
    wr(0, cfgw(0, 7, 1, 0));
    load(0);
    rd(1, v); chk("R5 index wrapped after full load", v, 0);

    // Mode request deferred until frame start
    wr(0, cfgw(0, 7, 1, 2));
    rd(3, v); chk("R9 status before strobe", v, 0);
    px(10, 20, 30, 3, o_r, o_g, o_b);
    chk("R9 still bypass before strobe", o_r, byp(10));
    strobe();
    for (int d = 0; d < 4; d++) begin
      int exp_s;
      exp_s = (d == 1) ? 3 : (d == 2) ? 4 : 1;
      dgam_rom = d[1:0];
      rd(3, v); chk("R10 status bank A", v, exp_s);
    end
    dgam_rom = 2'd0;
    sweep(0, "R1 R8 bank A");

    // Load bank B while A is in use
    wr(0, cfgw(1, 7, 1, 2));
    wr(1, 0);
    wr(2, fb(0, 0));
    rd(1, v); chk("R3 step after red", v, 256);
    wr(2, fb(0, 1));
    rd(1, v); chk("R3 step after green", v, 512);
    wr(2, fb(0, 2));
    rd(1, v); chk("R3 index after blue", v, 1);
    load(1);
    px(0, 100, 255, 1, o_r, o_g, o_b);
    chk("R7 bank A untouched r", o_r, fa(0, 0));
    chk("R7 bank A untouched g", o_g, fa(100, 1));
    chk("R7 bank A untouched b", o_b, fa(255, 2));

    wr(0, cfgw(1, 7, 1, 3));
    strobe();
    for (int d = 0; d < 3; d++) begin
      dgam_rom = d[1:0];
      rd(3, v); chk("R10 status bank B", v, (d == 0) ? 2 : (d == 1) ? 5 : 6);
    end
    dgam_rom = 2'd0;
    sweep(1, "R1 R8 bank B");

    // Write mask: green only
    wr(0, cfgw(1, 2, 1, 3));
    wr(1, 5);
    wr(2, 111); wr(2, 222); wr(2, 333);
    rd(1, v); chk("R4 masked slots still step", v, 6);
    px(5, 5, 5, 0, o_r, o_g, o_b);
    chk("R4 red kept", o_r, fb(5, 0));
    chk("R4 green written", o_g, 222);
    chk("R4 blue kept", o_b, fb(5, 2));

    // Power gating
    wr(0, cfgw(1, 7, 0, 3));
    wr(1, 10);
    wr(2, 999); wr(2, 998);
    rd(1, v); chk("R6 index held while unpowered", v, 10);
    px(10, 10, 10, 2, o_r, o_g, o_b);
    chk("R6 red unchanged", o_r, fb(10, 0));
    chk("R6 green unchanged", o_g, fb(10, 1));

    // Wrap from 255, then red of entry 0
    wr(0, cfgw(1, 0, 1, 3));
    wr(1, 255);
    wr(2, 1); wr(2, 2);
    rd(1, v); chk("R3 partial step", v, 255 + 512);
    wr(2, 3);
    rd(1, v); chk("R5 wrap to 0", v, 0);
    px(255, 255, 255, 3, o_r, o_g, o_b);
    chk("R4 mask 0 keeps entry 255", o_g, fb(255, 1));
    wr(0, cfgw(1, 1, 1, 3));
    wr(2, 77);
    px(0, 0, 0, 0, o_r, o_g, o_b);
    chk("R5 first write after wrap lands red 0", o_r, 77);
    chk("R5 green 0 unchanged", o_g, fb(0, 1));

    // Back to bypass via mode 1
    wr(0, cfgw(1, 1, 1, 1));
    strobe();
    rd(3, v); chk("R10 status bypass", v, 0);
    px(200, 1, 128, 1, o_r, o_g, o_b);
    chk("R8 mode 1 bypass r", o_r, byp(200));
    chk("R8 mode 1 bypass b", o_b, byp(128));
    @(negedge clk);
    chk("R11 outputs hold when idle", out_r, byp(200));

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule